// File: doc/BRIEF.md
# Pruned Add-Compare-Select Core with Look-Ahead Best Metric

This block is the add-compare-select core of a 64-state trellis decoder for a rate 1/2, constraint length 7 convolutional code. On each accepted step it takes four branch metrics, one for each possible pair of coded bits. It updates the path metric of every state and emits one decision bit per state. Alongside this it keeps a mask of surviving states. A state drops out of the search when its new metric lies more than a programmable margin above the best metric of the step. A dropped state is held at the saturated maximum, so it never wins a later comparison. Branch metrics come from quantized soft symbols of up to 7 bits each, and their sum fits the 8-bit branch metric field.

The best metric is not found by scanning the freshly selected metrics. States are grouped by the coded pair they would emit for input 0. Every state in such a group is extended by the same cheapest branch. The best new metric is therefore the minimum, over groups, of the group's stored minimum plus that group's cheapest branch metric. This is computed from registered state, in parallel with the compare-select lanes, so no 64-way search lies in the feedback path. When the best metric reaches half of full scale, it is subtracted from every surviving metric in the same update.

Top module: `vd_pruned_acs`

## Requirements
- R1: State j (bits j[5:0]) has predecessors {j[4:0],0} and {j[4:0],1}, reached with input bit j[5]. The coded pair of a transition from source s with input u is {c0,c1}, where c0 is the parity of ({u,s} AND 7'o133) and c1 is the parity of ({u,s} AND 7'o171). The branch metric used is field c0*2+c1 of bm_i (field k at bits [8k+7:8k]). The new metric is the smaller of the two candidate sums.
- R2: dec_o[j] is 1 exactly when the candidate through predecessor {j[4:0],1} is strictly smaller than the one through {j[4:0],0}. A tie gives 0.
- R3: Candidate sums saturate at 2^12-1. A purged predecessor contributes the value 2^12-1.
- R4: best_o equals the minimum over all 64 states of the selected new metrics, taken before normalization.
- R5: After a step, a state survives (mask_o[j]=1) only if at least one predecessor survived and its selected metric is at most best_o + thresh_i. A purged state's stored metric is 2^12-1.
- R6: When the best metric of a step is at least 2048, it is subtracted from every surviving state's metric in that same step.
- R7: start_i seeds the trellis in one cycle: state 0 gets metric 0 and is the only survivor. start_i takes priority over bm_valid_i, and the step raises no out_valid_o.
- R8: The results of a step accepted at a clock edge appear on dec_o, mask_o and best_o after that edge, with out_valid_o high for exactly that one cycle.
- R9: While bm_valid_i and start_i are low, the metrics and the mask do not change and out_valid_o is low.
- R10: After reset, out_valid_o is 0 and the trellis is in the seeded state of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Re-seed the trellis at state 0 |
| bm_valid_i | input | 1 | Accept one trellis step |
| bm_i | input | 32 | Four 8-bit branch metrics, indexed by coded pair |
| thresh_i | input | 12 | Pruning margin above the best metric |
| out_valid_o | output | 1 | Step results valid |
| dec_o | output | 64 | Per-state decision bits |
| mask_o | output | 64 | Surviving-state mask |
| best_o | output | 12 | Best metric of the step, before normalization |

## Verification
The assertions rely on start_i or reset being applied before the first step, so that state 0 is a survivor. From then on the best state always survives, and the survivor mask is never empty. The lower-bound and exactness checks on the look-ahead value assume that purged states really hold the saturated maximum. They also assume that the two coded pairs from one source are bitwise complements, which the chosen generators ensure. The stimulus issues start_i before every sequence of steps, holds each input stable across its accepting edge, and keeps branch metrics within the 8-bit field.

// File: rtl/vd_acs_pkg.sv
package vd_acs_pkg;
  localparam int NUM_STATES = 64;
  localparam int STATE_BITS = 6;
  localparam int NUM_PAIRS  = 4;
  localparam logic [6:0] GEN_A = 7'o133;
  localparam logic [6:0] GEN_B = 7'o171;

  // coded pair {c0,c1} emitted when input u leaves source state src
  function automatic logic [1:0] branch_label(input logic [STATE_BITS-1:0] src,
                                              input logic u);
    logic [6:0] reg_w;
    reg_w = {u, src};
    return {^(reg_w & GEN_A), ^(reg_w & GEN_B)};
  endfunction
endpackage

// File: rtl/vd_best_lookahead.sv
module vd_best_lookahead
  import vd_acs_pkg::*;
#(
  parameter int MW  = 12,
  parameter int BMW = 8
) (
  input  logic [NUM_STATES-1:0][MW-1:0] metric_i,
  input  logic [NUM_PAIRS-1:0][BMW-1:0] bm_i,
  output logic [MW-1:0]                 best_o
);
  localparam logic [MW-1:0] PM_MAX = '1;

  logic [NUM_PAIRS-1:0][MW-1:0] grp_min;
  logic [MW-1:0]                best_w;

  // per-group minimum of the stored metrics (group = pair for input 0)
  always_comb begin
    grp_min = {NUM_PAIRS{PM_MAX}};
    for (int p = 0; p < NUM_STATES; p++) begin
      logic [1:0] g;
      g = branch_label(STATE_BITS'(p), 1'b0);
      if (metric_i[p] < grp_min[g]) grp_min[g] = metric_i[p];
    end
  end

  // best of group minimum plus the group's cheaper branch
  always_comb begin
    best_w = PM_MAX;
    for (int c = 0; c < NUM_PAIRS; c++) begin
      logic [1:0]     cc;
      logic [BMW-1:0] cheap;
      logic [MW:0]    sum;
      logic [MW-1:0]  sat;
      cc    = 2'(c);
      cheap = (bm_i[cc] < bm_i[cc ^ 2'b11]) ? bm_i[cc] : bm_i[cc ^ 2'b11];
      sum   = {1'b0, grp_min[cc]} + (MW+1)'(cheap);
      sat   = sum[MW] ? PM_MAX : sum[MW-1:0];
      if (sat < best_w) best_w = sat;
    end
  end

  assign best_o = best_w;
endmodule

// File: rtl/vd_acs_lane.sv
module vd_acs_lane
  import vd_acs_pkg::*;
#(
  parameter int MW  = 12,
  parameter int BMW = 8,
  parameter int IDX = 0
) (
  input  logic [MW-1:0]                 pm0_i,
  input  logic [MW-1:0]                 pm1_i,
  input  logic                          v0_i,
  input  logic                          v1_i,
  input  logic [NUM_PAIRS-1:0][BMW-1:0] bm_i,
  input  logic [MW-1:0]                 best_i,
  input  logic [MW-1:0]                 thresh_i,
  output logic                          dec_o,
  output logic                          any_o,
  output logic                          valid_o,
  output logic [MW-1:0]                 sel_o,
  output logic [MW-1:0]                 metric_o
);
  localparam logic [MW-1:0]         PM_MAX = '1;
  localparam logic                  IN_BIT = 1'((IDX >> 5) & 1);
  localparam logic [STATE_BITS-1:0] SRC0   = STATE_BITS'((IDX % 32) * 2);
  localparam logic [STATE_BITS-1:0] SRC1   = SRC0 | STATE_BITS'(1);
  localparam logic [1:0]            LBL0   = branch_label(SRC0, IN_BIT);
  localparam logic [1:0]            LBL1   = branch_label(SRC1, IN_BIT);

  function automatic logic [MW-1:0] sat_add(input logic [MW-1:0] m,
                                            input logic [BMW-1:0] b);
    logic [MW:0] s;
    s = {1'b0, m} + (MW+1)'(b);
    return s[MW] ? PM_MAX : s[MW-1:0];
  endfunction

  logic [MW-1:0] cand0, cand1, sel_w;
  logic [MW:0]   limit;
  logic          over, keep, norm;

  always_comb begin
    cand0    = v0_i ? sat_add(pm0_i, bm_i[LBL0]) : PM_MAX;
    cand1    = v1_i ? sat_add(pm1_i, bm_i[LBL1]) : PM_MAX;
    dec_o    = (cand1 < cand0);
    sel_w    = dec_o ? cand1 : cand0;
    limit    = {1'b0, best_i} + {1'b0, thresh_i};
    over     = ({1'b0, sel_w} > limit);
    keep     = (v0_i | v1_i) & ~over;
    norm     = best_i[MW-1];
    any_o    = v0_i | v1_i;
    valid_o  = keep;
    sel_o    = sel_w;
    if (!keep)     metric_o = PM_MAX;
    else if (norm) metric_o = sel_w - best_i;
    else           metric_o = sel_w;
  end
endmodule

// File: rtl/vd_pruned_acs.sv
module vd_pruned_acs
  import vd_acs_pkg::*;
#(
  parameter int MW  = 12,
  parameter int BMW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  bm_valid_i,
  input  logic [4*BMW-1:0]      bm_i,
  input  logic [MW-1:0]         thresh_i,
  output logic                  out_valid_o,
  output logic [NUM_STATES-1:0] dec_o,
  output logic [NUM_STATES-1:0] mask_o,
  output logic [MW-1:0]         best_o
);
  localparam int            NS     = NUM_STATES;
  localparam logic [MW-1:0] PM_MAX = '1;

  logic [NS-1:0][MW-1:0]        metric_q, metric_d, lane_m, lane_sel;
  logic [NS-1:0]                valid_q, valid_d, lane_v, lane_dec, lane_any, lane_hit;
  logic [NS-1:0]                dec_q, dec_d;
  logic [MW-1:0]                best_q, best_d, best_w;
  logic                         ov_q, ov_d;
  logic [NUM_PAIRS-1:0][BMW-1:0] bm_w;
  logic                         accept_w, upd_en;

  assign bm_w     = bm_i;
  assign accept_w = bm_valid_i & ~start_i;
  assign upd_en   = start_i | bm_valid_i;

  vd_best_lookahead #(.MW(MW), .BMW(BMW)) u_look (
    .metric_i (metric_q),
    .bm_i     (bm_w),
    .best_o   (best_w)
  );

  for (genvar j = 0; j < NS; j++) begin : g_lane
    localparam int P0 = (j % 32) * 2;
    localparam int P1 = P0 + 1;
    vd_acs_lane #(.MW(MW), .BMW(BMW), .IDX(j)) u_lane (
      .pm0_i    (metric_q[P0]),
      .pm1_i    (metric_q[P1]),
      .v0_i     (valid_q[P0]),
      .v1_i     (valid_q[P1]),
      .bm_i     (bm_w),
      .best_i   (best_w),
      .thresh_i (thresh_i),
      .dec_o    (lane_dec[j]),
      .any_o    (lane_any[j]),
      .valid_o  (lane_v[j]),
      .sel_o    (lane_sel[j]),
      .metric_o (lane_m[j])
    );
    assign lane_hit[j] = lane_any[j] && (lane_sel[j] == best_w);

    // look-ahead never exceeds a live selected metric
    p_lookahead_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_w && lane_any[j]) |-> (lane_sel[j] >= best_w));

    // purged states sit at saturated maximum
    p_purged_at_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_q[j] |-> (metric_q[j] == PM_MAX));

    // after a normalizing step every survivor is within the margin of zero
    p_norm_rebased_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_w && best_w[MW-1]) |=> (!valid_q[j] || metric_q[j] <= $past(thresh_i)));
  end

  // next-state process
  always_comb begin
    metric_d = metric_q;
    valid_d  = valid_q;
    dec_d    = dec_q;
    best_d   = best_q;
    ov_d     = 1'b0;
    if (start_i) begin
      metric_d    = {NS{PM_MAX}};
      metric_d[0] = '0;
      valid_d     = NS'(1);
    end else if (bm_valid_i) begin
      metric_d = lane_m;
      valid_d  = lane_v;
      dec_d    = lane_dec;
      best_d   = best_w;
      ov_d     = 1'b1;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      metric_q    <= {{(NS-1){PM_MAX}}, {MW{1'b0}}};
      valid_q     <= NS'(1);
      dec_q       <= '0;
      best_q      <= '0;
      ov_q        <= 1'b0;
    end else begin
      ov_q <= ov_d;
      if (upd_en) begin
        metric_q <= metric_d;
        valid_q  <= valid_d;
      end
      if (accept_w) begin
        dec_q  <= dec_d;
        best_q <= best_d;
      end
    end
  end

  assign out_valid_o = ov_q;
  assign dec_o       = dec_q;
  assign mask_o      = valid_q;
  assign best_o      = best_q;

  // the look-ahead value is attained by some live state
  p_lookahead_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |-> (lane_hit != '0));

  p_survivor_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (mask_o != '0));

  p_start_seed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_q == NS'(1) && metric_q[0] == '0 && !out_valid_o));

  p_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> out_valid_o);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bm_valid_i && !start_i) |=> ($stable(metric_q) && $stable(valid_q) && !out_valid_o));
endmodule

// File: tb/vd_pruned_acs_tb.sv
module vd_pruned_acs_tb_top;
  localparam int MW = 12;
  localparam int BMW = 8;
  localparam int PMAX = 4095;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic bm_valid_i = 1'b0;
  logic [4*BMW-1:0] bm_i = '0;
  logic [MW-1:0] thresh_i = '0;
  logic out_valid_o;
  logic [63:0] dec_o, mask_o;
  logic [MW-1:0] best_o;

  vd_pruned_acs #(.MW(MW), .BMW(BMW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bm_valid_i(bm_valid_i),
    .bm_i(bm_i), .thresh_i(thresh_i), .out_valid_o(out_valid_o),
    .dec_o(dec_o), .mask_o(mask_o), .best_o(best_o)
  );

  always #5 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference trellis state
  int  pm[64];
  bit  pv[64];
  logic [63:0] e_dec, e_mask;
  int  e_best;

  // stimulus table: {bm3, bm2, bm1, bm0, thresh}
  localparam logic [43:0] VEC [16] = '{
    {8'd10, 8'd20, 8'd30, 8'd0,   12'd4095},
    {8'd5,  8'd5,  8'd5,  8'd5,   12'd4095},
    {8'd0,  8'd40, 8'd40, 8'd80,  12'd4095},
    {8'd12, 8'd3,  8'd7,  8'd9,   12'd60},
    {8'd100,8'd0,  8'd50, 8'd25,  12'd100},
    {8'd1,  8'd2,  8'd3,  8'd4,   12'd4095},
    {8'd60, 8'd60, 8'd0,  8'd0,   12'd40},
    {8'd254,8'd0,  8'd127,8'd127, 12'd300},
    {8'd33, 8'd44, 8'd55, 8'd66,  12'd20},
    {8'd0,  8'd0,  8'd0,  8'd0,   12'd0},
    {8'd9,  8'd18, 8'd27, 8'd36,  12'd15},
    {8'd70, 8'd10, 8'd10, 8'd70,  12'd4095},
    {8'd2,  8'd200,8'd2,  8'd200, 12'd50},
    {8'd15, 8'd15, 8'd16, 8'd16,  12'd8},
    {8'd0,  8'd90, 8'd45, 8'd3,   12'd500},
    {8'd88, 8'd11, 8'd22, 8'd33,  12'd4095}
  };

  function automatic int pair_of(int src, int u);
    int r, a, b;
    r = (u << 6) | src;
    a = $countones(r & 7'o133) & 1;
    b = $countones(r & 7'o171) & 1;
    return a * 2 + b;
  endfunction

  task automatic model_seed();
    for (int k = 0; k < 64; k++) begin
      pm[k] = PMAX;
      pv[k] = 1'b0;
    end
    pm[0] = 0;
    pv[0] = 1'b1;
  endtask

  task automatic model_step(input int bm[4], input int thr);
    int sel[64];
    bit any[64];
    for (int j = 0; j < 64; j++) begin
      int u, s0, s1, c0, c1;
      u  = j / 32;
      s0 = (j % 32) * 2;
      s1 = s0 + 1;
      c0 = pv[s0] ? ((pm[s0] + bm[pair_of(s0, u)] > PMAX) ? PMAX : pm[s0] + bm[pair_of(s0, u)]) : PMAX;
      c1 = pv[s1] ? ((pm[s1] + bm[pair_of(s1, u)] > PMAX) ? PMAX : pm[s1] + bm[pair_of(s1, u)]) : PMAX;
      e_dec[j] = (c1 < c0);
      sel[j] = (c1 < c0) ? c1 : c0;
      any[j] = pv[s0] | pv[s1];
    end
    e_best = PMAX;
    for (int j = 0; j < 64; j++) if (sel[j] < e_best) e_best = sel[j];
    for (int j = 0; j < 64; j++) begin
      pv[j] = any[j] && (sel[j] <= e_best + thr);
      e_mask[j] = pv[j];
      pm[j] = pv[j] ? ((e_best >= 2048) ? sel[j] - e_best : sel[j]) : PMAX;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    model_seed();
  endtask

  task automatic do_step(input int b0, input int b1, input int b2, input int b3,
                         input int thr, input string tag);
    int bm[4];
    bm = '{b0, b1, b2, b3};
    @(negedge clk);
    bm_i = {8'(b3), 8'(b2), 8'(b1), 8'(b0)};
    thresh_i = 12'(thr);
    bm_valid_i = 1'b1;
    @(negedge clk);
    bm_valid_i = 1'b0;
    model_step(bm, thr);
    check(out_valid_o === 1'b1, {tag, " R8 strobe"}, 64'(out_valid_o), 64'd1);
    check(dec_o === e_dec, {tag, " R1 R2 decisions"}, dec_o, e_dec);
    check(mask_o === e_mask, {tag, " R3 R5 mask"}, mask_o, e_mask);
    check(best_o === 12'(e_best), {tag, " R4 best"}, 64'(best_o), 64'(e_best));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(out_valid_o === 1'b0, "R10 out_valid after reset", 64'(out_valid_o), 64'd0);
    check(mask_o === 64'd1, "R10 mask after reset", mask_o, 64'd1);
    model_seed();

    // table walk
    for (int i = 0; i < 16; i++) begin
      do_step(int'(VEC[i][19:12]), int'(VEC[i][27:20]), int'(VEC[i][35:28]),
              int'(VEC[i][43:36]), int'(VEC[i][11:0]), $sformatf("vec%0d", i));
    end

    // R9: idle cycles leave state and strobe untouched
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid_o === 1'b0, "R9 idle strobe", 64'(out_valid_o), 64'd0);
      check(mask_o === e_mask, "R9 idle mask", mask_o, e_mask);
    end
    do_step(7, 3, 9, 1, 4095, "R9 resume");

    // R7: start wins over a simultaneous step
    @(negedge clk);
    start_i = 1'b1;
    bm_valid_i = 1'b1;
    bm_i = {8'd1, 8'd1, 8'd1, 8'd1};
    @(negedge clk);
    start_i = 1'b0;
    bm_valid_i = 1'b0;
    model_seed();
    check(out_valid_o === 1'b0, "R7 no strobe on start", 64'(out_valid_o), 64'd0);
    check(mask_o === 64'd1, "R7 seeded mask", mask_o, 64'd1);
    do_step(4, 8, 12, 16, 4095, "R7 first step");

    // R6: uniform growth until normalization
    do_start();
    for (int k = 1; k <= 12; k++) begin
      do_step(200, 200, 200, 200, 4095, $sformatf("R6 grow%0d", k));
      if (k == 11) check(best_o === 12'd2200, "R6 pre-norm best", 64'(best_o), 64'd2200);
      if (k == 12) check(best_o === 12'd200, "R6 rebased best", 64'(best_o), 64'd200);
    end

    // R3: spreading metrics reach saturation while best stays at zero
    do_start();
    for (int k = 0; k < 20; k++) begin
      do_step(0, 255, 255, 255, 4095, $sformatf("R3 sat%0d", k));
    end

    // R5: zero margin keeps only the best states
    do_start();
    for (int k = 0; k < 8; k++) begin
      do_step(k, 3 + k, 17, 2, 0, $sformatf("R5 tight%0d", k));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule